// File: doc/BRIEF.md
# Tuning Oscillator with Deferred Frequency and Phase Updates

This block moves a complex baseband stream up to an intermediate frequency. A 32-bit phase accumulator advances by the active tuning word on every clock. A programmable phase offset is added to its upper bits. The sum, with optional phase dither below the truncation point, is cut down to a 12-bit index. That index drives a sine/cosine generator built on a quarter-wave table held in logic. The mixer then rotates the I/Q sample and can produce a complex result or only the real part.

A new tuning word or phase offset is first written to a shadow register, and a sync strobe then starts a countdown. Frequency and offset each have their own shadow register and their own hold-off count, so each value reaches its active register on a cycle that can be planned. Several channels can therefore hop frequency or step their relative phase (beam steering) on one common sync. An amplitude dither option randomises the rounding of the mixer output.

Top module: `tune_nco`

## Requirements
- R1: After reset the accumulator (`phase_o`) is 0. On every rising clock edge it becomes its previous value plus the active tuning word, modulo 2^32.
- R2: A write to the frequency shadow (`freq_wr_i`) does not change the step of the accumulator until a sync-started countdown transfers it. A write in the same cycle as the transfer is not part of that transfer.
- R3: A sync loads the frequency countdown with `freq_hold_i`. The countdown decrements once per clock, and on the edge where it would go from 1 to 0 the shadow word becomes active. With a hold of H≥1 and sync high in cycle n, the new step is first seen between the values of `phase_o` after edges n+H+1 and n+H+2. A hold of 0 never transfers.
- R4: The phase offset has its own shadow, its own countdown loaded from `offs_hold_i` and the same transfer rule as R3. The active 16-bit offset is added at bits [31:16] of the accumulator value, and the two countdowns run independently.
- R5: A sync that arrives while a countdown is running restarts that countdown from the hold input, even in the cycle in which a transfer would have occurred. The pending transfer is then abandoned.
- R6: The table index k is bits [31:20] of accumulator + offset. Sine is round(32767·sin(2π(k+0.5)/4096)), and cosine is the sine of index (k+1024) mod 4096.
- R7: In complex mode (`cplx_en_i`=1) the outputs are I·cos−Q·sin and I·sin+Q·cos, shifted right arithmetically by 15. The I, Q and mode presented in cycle n appear on the outputs after edge n+2.
- R8: In real mode (`cplx_en_i`=0) `q_out` is 0 and `i_out` is I·cos−Q·sin as in R7.
- R9: Results outside the 16-bit signed range clip to 32767 or −32768 and do not wrap.
- R10: With `pdith_en_i`=1 a 16-bit LFSR value is added at bits [19:4] of the phase. This moves the index by at most one step. With it off, the outputs are exact.
- R11: With `adith_en_i`=1 a pseudo-random bit adds 2^14 before the shift by 15, so each output differs by at most 1 from the undithered value.
- R12: While `rst_n` is low, `phase_o`, `i_out` and `q_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Sync strobe that starts both countdowns |
| freq_wr_i | input | 1 | Load the frequency shadow |
| freq_word_i | input | 32 | New tuning word |
| freq_hold_i | input | 16 | Countdown length for frequency transfer |
| offs_wr_i | input | 1 | Load the phase-offset shadow |
| offs_word_i | input | 16 | New phase offset |
| offs_hold_i | input | 16 | Countdown length for offset transfer |
| cplx_en_i | input | 1 | 1: complex output, 0: real only |
| pdith_en_i | input | 1 | Enable phase dither |
| adith_en_i | input | 1 | Enable amplitude dither |
| i_in | input | 16 | Baseband in-phase sample, signed |
| q_in | input | 16 | Baseband quadrature sample, signed |
| phase_o | output | 32 | Phase accumulator |
| i_out | output | 16 | Mixed in-phase output, signed |
| q_out | output | 16 | Mixed quadrature output, signed |

## Verification
A tuning word of 2^20 walks the index through all 4096 entries with a full-scale pure-I input. This separates errors in quadrant mirroring and cosine placement from errors in mixing. Mixed I/Q inputs at an irregular tuning word expose sign mistakes in the cross terms, and real mode shows whether the Q path is forced to zero. Full-scale inputs at a 45° offset tell clipping apart from wrapping. Updates are issued with holds of 0, 1 and N, with a resync mid-count, with a resync on the transfer cycle itself, and with different frequency and offset holds on one sync; the cycle-exact accumulator check pins each landing edge.

// File: rtl/tnco_pkg.sv
package tnco_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
    endfunction
endpackage

// File: rtl/tnco_holdoff.sv
module tnco_holdoff #(
    parameter int VW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic          wr_i,
    input  logic [VW-1:0] word_i,
    input  logic [HW-1:0] hold_i,
    output logic [VW-1:0] act_o,
    output logic [HW-1:0] cnt_o
);
    typedef struct packed {
        logic [VW-1:0] shadow;
        logic [VW-1:0] active;
        logic [HW-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.cnt = hold_i;
        end else if (st_q.cnt == HW'(1)) begin
            st_d.active = st_q.shadow;
            st_d.cnt    = '0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - HW'(1);
        end
        if (wr_i) st_d.shadow = word_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.active;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/tnco_sincos.sv
module tnco_sincos #(
    parameter int LW = 12,
    parameter int AW = 16
) (
    input  logic [LW-1:0]        idx_i,
    output logic signed [AW-1:0] sin_o,
    output logic signed [AW-1:0] cos_o
);
    localparam int QB      = LW - 2;
    localparam int QN      = 1 << QB;
    localparam int AMP_MAX = (1 << (AW - 1)) - 1;

    function automatic int qval(input int j);
        real a;
        a = real'(AMP_MAX) * $sin(6.283185307179586 * (real'(j) + 0.5) / real'(4 * QN));
        return $rtoi(a + 0.5);
    endfunction

    logic signed [AW-1:0] qtab [QN];

    for (genvar j = 0; j < QN; j++) begin : g_tab
        assign qtab[j] = AW'(qval(j));
    end

    logic [LW-1:0]        cidx;
    logic signed [AW-1:0] smag, cmag;

    always_comb begin
        cidx  = idx_i + LW'(QN);
        smag  = qtab[idx_i[LW-2] ? ~idx_i[QB-1:0] : idx_i[QB-1:0]];
        cmag  = qtab[cidx[LW-2]  ? ~cidx[QB-1:0]  : cidx[QB-1:0]];
        sin_o = idx_i[LW-1] ? -smag : smag;
        cos_o = cidx[LW-1]  ? -cmag : cmag;
    end
endmodule

// File: rtl/tnco_mix.sv
module tnco_mix #(
    parameter int DW = 16,
    parameter int AW = 16
) (
    input  logic signed [AW-1:0] cos_i,
    input  logic signed [AW-1:0] sin_i,
    input  logic signed [DW-1:0] di_i,
    input  logic signed [DW-1:0] dq_i,
    input  logic                 cplx_i,
    input  logic                 abit_i,
    output logic signed [DW-1:0] oi_o,
    output logic signed [DW-1:0] oq_o
);
    localparam int SW = DW + AW + 1;
    localparam logic signed [SW-1:0] HI = SW'((1 << (DW - 1)) - 1);
    localparam logic signed [SW-1:0] LO = SW'(-(1 << (DW - 1)));

    function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > HI) return DW'(HI);
        if (v < LO) return DW'(LO);
        return DW'(v);
    endfunction

    logic signed [SW-1:0] bias, si, sq;

    always_comb begin
        bias = abit_i ? (SW'(1) <<< (AW - 2)) : '0;
        si   = di_i * cos_i - dq_i * sin_i + bias;
        sq   = di_i * sin_i + dq_i * cos_i + bias;
        oi_o = clip(si >>> (AW - 1));
        oq_o = cplx_i ? clip(sq >>> (AW - 1)) : '0;
    end
endmodule

// File: rtl/tune_nco.sv
module tune_nco #(
    parameter int PW = 32,
    parameter int OW = 16,
    parameter int HW = 16,
    parameter int DW = 16,
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_i,
    input  logic                 freq_wr_i,
    input  logic [PW-1:0]        freq_word_i,
    input  logic [HW-1:0]        freq_hold_i,
    input  logic                 offs_wr_i,
    input  logic [OW-1:0]        offs_word_i,
    input  logic [HW-1:0]        offs_hold_i,
    input  logic                 cplx_en_i,
    input  logic                 pdith_en_i,
    input  logic                 adith_en_i,
    input  logic signed [DW-1:0] i_in,
    input  logic signed [DW-1:0] q_in,
    output logic [PW-1:0]        phase_o,
    output logic signed [DW-1:0] i_out,
    output logic signed [DW-1:0] q_out
);
    import tnco_pkg::*;

    localparam int OSH = PW - OW;
    localparam int DSH = PW - LW - LFSR_W;

    typedef struct packed {
        logic [PW-1:0]        acc;
        logic [LFSR_W-1:0]    lfsr;
        logic signed [AW-1:0] c;
        logic signed [AW-1:0] s;
        logic signed [DW-1:0] di;
        logic signed [DW-1:0] dq;
        logic                 cplx;
        logic                 abit;
        logic signed [DW-1:0] oi;
        logic signed [DW-1:0] oq;
    } nco_st_t;

    nco_st_t st_d, st_q;

    logic [PW-1:0]        fw_act;
    logic [HW-1:0]        fcnt;
    logic [OW-1:0]        off_act;
    logic [HW-1:0]        ocnt;
    logic [PW-1:0]        ph_sum;
    logic [LW-1:0]        idx;
    logic signed [AW-1:0] sin_w, cos_w;
    logic signed [DW-1:0] mix_i, mix_q;
    logic                 cplx_stage;

    tnco_holdoff #(.VW(PW), .HW(HW)) u_fhold (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .wr_i(freq_wr_i),
        .word_i(freq_word_i), .hold_i(freq_hold_i), .act_o(fw_act), .cnt_o(fcnt)
    );

    tnco_holdoff #(.VW(OW), .HW(HW)) u_ohold (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .wr_i(offs_wr_i),
        .word_i(offs_word_i), .hold_i(offs_hold_i), .act_o(off_act), .cnt_o(ocnt)
    );

    always_comb begin
        ph_sum = st_q.acc + (PW'(off_act) << OSH)
               + (pdith_en_i ? (PW'(st_q.lfsr) << DSH) : '0);
        idx    = LW'(ph_sum >> (PW - LW));
    end

    tnco_sincos #(.LW(LW), .AW(AW)) u_sc (
        .idx_i(idx), .sin_o(sin_w), .cos_o(cos_w)
    );

    tnco_mix #(.DW(DW), .AW(AW)) u_mix (
        .cos_i(st_q.c), .sin_i(st_q.s), .di_i(st_q.di), .dq_i(st_q.dq),
        .cplx_i(st_q.cplx), .abit_i(st_q.abit), .oi_o(mix_i), .oq_o(mix_q)
    );

    always_comb begin
        st_d      = st_q;
        st_d.acc  = st_q.acc + fw_act;
        st_d.lfsr = lfsr_next(st_q.lfsr);
        st_d.c    = cos_w;
        st_d.s    = sin_w;
        st_d.di   = i_in;
        st_d.dq   = q_in;
        st_d.cplx = cplx_en_i;
        st_d.abit = adith_en_i & st_q.lfsr[0];
        st_d.oi   = mix_i;
        st_d.oq   = mix_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= LFSR_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o    = st_q.acc;
    assign i_out      = st_q.oi;
    assign q_out      = st_q.oq;
    assign cplx_stage = st_q.cplx;
endmodule

// File: rtl/tnco_chk.sv
module tnco_chk #(
    parameter int PW = 32,
    parameter int OW = 16,
    parameter int HW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_i,
    input logic [HW-1:0] freq_hold_i,
    input logic [PW-1:0] phase_o,
    input logic [DW-1:0] q_out,
    input logic [PW-1:0] fw_act,
    input logic [HW-1:0] fcnt,
    input logic [OW-1:0] off_act,
    input logic [HW-1:0] ocnt,
    input logic          cplx_stage
);
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == $past(phase_o) + $past(fw_act)); // R1

    AST_FREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fcnt != HW'(1)) |=> $stable(fw_act)); // R2

    AST_OFFS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ocnt != HW'(1)) |=> $stable(off_act)); // R4

    AST_SYNC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (fcnt == $past(freq_hold_i))); // R5

    AST_REAL_QZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cplx_stage |=> (q_out == '0)); // R8
endmodule

bind tune_nco tnco_chk #(.PW(PW), .OW(OW), .HW(HW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .freq_hold_i(freq_hold_i),
    .phase_o(phase_o), .q_out(q_out), .fw_act(fw_act), .fcnt(fcnt),
    .off_act(off_act), .ocnt(ocnt), .cplx_stage(cplx_stage)
);

// File: tb/sim_tune_nco.sv
`timescale 1ns/1ps
module sim_tune_nco;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               sync_i = 1'b0, freq_wr_i = 1'b0, offs_wr_i = 1'b0;
    logic [31:0]        freq_word_i = '0;
    logic [15:0]        freq_hold_i = '0, offs_word_i = '0, offs_hold_i = '0;
    logic               cplx_en_i = 1'b1, pdith_en_i = 1'b0, adith_en_i = 1'b0;
    logic signed [15:0] i_in = '0, q_in = '0;
    logic [31:0]        phase_o;
    logic signed [15:0] i_out, q_out;

    tune_nco u0 (.*);

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    typedef struct { int ei; int eq; int tol; string req; } exp_t;
    exp_t q_exp[$];

    // drive values
    logic               d_sync = 0, d_fwr = 0, d_pwr = 0, d_cplx = 1, d_pd = 0, d_ad = 0;
    logic [31:0]        d_fword = '0;
    logic [15:0]        d_fhold = '0, d_pword = '0, d_phold = '0;
    logic signed [15:0] d_i = '0, d_q = '0;

    // model state
    logic [31:0] acc_m = '0, fw_act_m = '0, fw_sh_m = '0;
    logic [15:0] po_act_m = '0, po_sh_m = '0;
    int          fcnt_m = 0, pcnt_m = 0;

    function automatic int bsin(input int k);
        real r;
        r = 32767.0 * $sin(6.283185307179586 * (real'(k) + 0.5) / 4096.0);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic int bsat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic tick();
        logic [31:0] ph;
        int k, c, s, tol;
        exp_t e;
        @(negedge clk);
        chk(phase_o === acc_m, "phase_o", phase_o, acc_m);
        sync_i = d_sync; freq_wr_i = d_fwr; freq_word_i = d_fword; freq_hold_i = d_fhold;
        offs_wr_i = d_pwr; offs_word_i = d_pword; offs_hold_i = d_phold;
        cplx_en_i = d_cplx; pdith_en_i = d_pd; adith_en_i = d_ad; i_in = d_i; q_in = d_q;
        ph = acc_m + {po_act_m, 16'h0};
        k  = int'(ph[31:20]);
        s  = bsin(k);
        c  = bsin((k + 1024) % 4096);
        tol = 0;
        if (d_pd) tol += (iabs(int'(d_i)) + iabs(int'(d_q))) * 51 / 32768 + 2;
        if (d_ad) tol += 1;
        e.ei  = bsat((longint'(d_i) * c - longint'(d_q) * s) >>> 15);
        e.eq  = d_cplx ? bsat((longint'(d_i) * s + longint'(d_q) * c) >>> 15) : 0;
        e.tol = tol;
        e.req = cur_req;
        q_exp.push_back(e);
        acc_m = acc_m + fw_act_m;
        if (d_sync) fcnt_m = int'(d_fhold);
        else if (fcnt_m == 1) begin fw_act_m = fw_sh_m; fcnt_m = 0; end
        else if (fcnt_m != 0) fcnt_m--;
        if (d_sync) pcnt_m = int'(d_phold);
        else if (pcnt_m == 1) begin po_act_m = po_sh_m; pcnt_m = 0; end
        else if (pcnt_m != 0) pcnt_m--;
        if (d_fwr) fw_sh_m = d_fword;
        if (d_pwr) po_sh_m = d_pword;
        d_sync = 0; d_fwr = 0; d_pwr = 0;
    endtask

    // monitor: compares outputs two edges after the inputs were applied
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q_exp.size() >= 3) begin
                e = q_exp.pop_front();
                total++;
                if (iabs(int'(i_out) - e.ei) > e.tol || iabs(int'(q_out) - e.eq) > e.tol) begin
                    bad++;
                    $display("FAIL %s out act=(%0d,%0d) exp=(%0d,%0d) tol=%0d",
                             e.req, i_out, q_out, e.ei, e.eq, e.tol);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R12";
        chk(phase_o == 0, "reset phase", phase_o, 0);
        chk(i_out == 0, "reset i_out", i_out, 0);
        chk(q_out == 0, "reset q_out", q_out, 0);
        rst_n = 1'b1;

        cur_req = "R1";
        d_i = 20000; d_q = 0; d_cplx = 1;
        d_fhold = 1; d_fword = 32'h0123_4567; d_fwr = 1; tick();
        d_sync = 1; tick();
        repeat (30) tick();

        cur_req = "R7";
        d_i = 12000; d_q = -9000;
        repeat (40) tick();

        cur_req = "R2";
        d_fword = 32'h0800_0000; d_fwr = 1; tick();
        repeat (20) tick();

        cur_req = "R3";
        d_fhold = 6; d_sync = 1; tick();
        repeat (12) tick();
        d_fhold = 0; d_fword = 32'h0000_1000; d_fwr = 1; tick();
        d_sync = 1; tick();
        repeat (10) tick();

        cur_req = "R5";
        d_fhold = 8; d_fword = 32'h0300_0000; d_fwr = 1; d_sync = 1; tick();
        repeat (3) tick();
        d_sync = 1; tick();
        repeat (12) tick();
        d_fhold = 3; d_fword = 32'h0500_0000; d_fwr = 1; d_sync = 1; tick();
        tick(); tick();
        d_sync = 1; tick();
        repeat (6) tick();

        cur_req = "R4";
        d_phold = 3; d_pword = 16'h4000; d_pwr = 1; tick();
        d_fhold = 0; d_sync = 1; tick();
        repeat (10) tick();
        d_fhold = 2; d_phold = 5; d_fword = 32'h0010_0000; d_fwr = 1;
        d_pword = 16'h0000; d_pwr = 1; tick();
        d_sync = 1; tick();
        repeat (10) tick();

        cur_req = "R6";
        d_i = 32767; d_q = 0;
        repeat (4100) tick();
        d_i = 0; d_q = 32767;
        repeat (20) tick();

        cur_req = "R8";
        d_cplx = 0; d_i = 15000; d_q = -22000;
        repeat (40) tick();
        d_i = -30000; d_q = 30000;
        repeat (20) tick();

        cur_req = "R9";
        d_cplx = 1;
        d_fhold = 1; d_fword = 32'h0; d_fwr = 1;
        d_phold = 1; d_pword = 16'h2000; d_pwr = 1; tick();
        d_sync = 1; tick();
        d_i = 32767; d_q = 32767;
        repeat (8) tick();
        d_i = -32768; d_q = -32768;
        repeat (8) tick();
        d_i = 32767; d_q = -32768;
        repeat (8) tick();

        cur_req = "R10";
        d_fword = 32'h0123_4567; d_fwr = 1; tick();
        d_sync = 1; tick();
        d_i = 25000; d_q = -18000; d_pd = 1;
        repeat (60) tick();

        cur_req = "R11";
        d_pd = 0; d_ad = 1;
        repeat (60) tick();
        d_ad = 0;
        repeat (3) tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule